// File: doc/BRIEF.md
# ROM/RAM Socket Address Decoder

This block maps a 20-bit byte address onto four memory sockets that sit at the very top of a 1 MB address space. Each socket can be left empty or can hold a read-only device of 8, 16 or 32 KB, or a writable device of 8 or 32 KB. The top socket (socket 3) must hold a read-only device. Its size fixes the size of every socket and the base of the whole region. A mode bit selects byte-wide operation, where the sockets are stacked one after another. It can also select halfword operation, where the sockets work in pairs: even bytes go to one device of the pair and odd bytes to the other.

Configuration requests arrive on a small port. Each request names a socket and a device kind. The block checks every request for legality. A rejected request raises an error flag for one cycle. On every access the block decodes the address into a hit flag, a socket number, an in-socket offset and a write-permitted flag. A small byte store stands in for each socket's device. Reads from that store return data one cycle later. Reads that hit nothing return 0xFF, and writes to read-only sockets are dropped.

Top module: `socket_decoder`

## Requirements
- R1: After reset every socket is empty, byte-wide mode is selected, `rd_data` is 0xFF, `cfg_err` is 0 and no address hits.
- R2: `cfg_kind` codes are 0 empty, 1 ROM 8 KB, 2 ROM 16 KB, 3 ROM 32 KB, 4 RAM 8 KB, 5 RAM 32 KB. Let S be socket 3's size. In byte-wide mode the region starts at 0x100000 − 4·S. Socket i covers [base + i·S, base + (i+1)·S − 1], and `hit_off` is the address minus the socket start. A socket hits only when it is configured.
- R3: In halfword mode (`mode_wide`=1) the region is split into two pairs of 2·S bytes each. The lower pair holds sockets 0 and 1, and the upper pair holds sockets 2 and 3. The even socket of a pair serves even addresses and the odd socket serves odd addresses. `hit_off` is the distance from the pair start divided by two.
- R4: A RAM request (codes 4 or 5) for socket 3 is rejected: `cfg_err` is 1 in the next cycle and socket 3 keeps its setting.
- R5: Any accepted request for socket 3 (codes 0 to 3) leaves sockets 0, 1 and 2 empty from the next cycle.
- R6: A request for socket 0, 1 or 2 with a nonzero code whose size differs from socket 3's size is rejected with `cfg_err`, and that socket becomes empty.
- R7: RAM exists only in 8 KB and 32 KB sizes, so no socket can be RAM while socket 3 is 16 KB. In halfword mode a RAM request for socket 2 is rejected with `cfg_err` and socket 2 becomes empty. Writes to sockets 2 and 3 are never permitted in halfword mode.
- R8: A write that hits a RAM socket stores `acc_wdata` at index `hit_off` mod 2^STORE_AW of that socket's store. A write that hits a ROM socket, or hits nothing, changes no stored byte.
- R9: A read (`acc_valid`=1, `acc_write`=0) drives `rd_data` in the next cycle: the stored byte on a hit, 0xFF on a miss. `rd_data` holds its value when no read is issued.
- R10: Codes 6 and 7 are rejected with `cfg_err` and change nothing. `cfg_err` is 1 only in the cycle after a rejected request.
- R11: After reset, byte j of socket i's store holds (j mod 256) XOR (i·64).
- R12: Configuration requests and mode changes take effect at the next clock edge. An access issued in the same cycle decodes against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_sock | input | 2 | Socket addressed by the request |
| cfg_kind | input | 3 | Requested device kind (codes in R2) |
| mode_set | input | 1 | Load `mode_wide` into the mode register |
| mode_wide | input | 1 | 1 selects halfword (paired) mode |
| cfg_err | output | 1 | Previous request was rejected |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 20 | Byte address |
| acc_wdata | input | 8 | Write data |
| hit | output | 1 | Address falls in a configured socket |
| hit_sock | output | 2 | Decoded socket number |
| hit_off | output | 15 | Offset within the socket |
| wr_ok | output | 1 | A write to this address would be stored |
| rd_data | output | 8 | Read data, one cycle after the read |

## Verification
The bench targets these cases:
- Reconfiguring socket 3 while the lower sockets hold data. A design that forgot to clear them would keep hitting at stale offsets under the new size.
- Size mismatches and RAM requests in 16 KB and halfword settings. A design that skipped those checks would accept a writable lower socket or a writable upper pair, and later writes would alter bytes the model keeps fixed.
- Odd and even addresses in halfword mode, and offsets above the store depth. These catch a swapped pair lane, an offset not halved, or a broken wrap.
- Reads that miss, and a configuration change issued in the same cycle as an access. A design that returned stale data on a miss, or decoded against the new settings too early, would disagree with the model in that cycle.

// File: rtl/socket_decoder.sv
module socket_decoder #(
  parameter int STORE_AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [1:0]  cfg_sock,
  input  logic [2:0]  cfg_kind,
  input  logic        mode_set,
  input  logic        mode_wide,
  output logic        cfg_err,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [19:0] acc_addr,
  input  logic [7:0]  acc_wdata,
  output logic        hit,
  output logic [1:0]  hit_sock,
  output logic [14:0] hit_off,
  output logic        wr_ok,
  output logic [7:0]  rd_data
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [3:0][1:0] sz;
  logic [3:0]      is_ram;
  logic            wide;
  logic [7:0]      mem [4][DEPTH];
  logic            in_region;
  logic            req_ram;
  logic [1:0]      req_sz;
  logic [1:0]      top_sz;

  assign req_ram = cfg_kind[2];
  assign req_sz  = cfg_kind[2] ? (cfg_kind[0] ? 2'd3 : 2'd1) : cfg_kind[1:0];
  assign top_sz  = sz[3];

  always_comb begin
    in_region = 1'b0;
    hit_sock  = 2'd0;
    hit_off   = 15'd0;
    case (top_sz)
      2'd1: begin
        in_region = &acc_addr[19:15];
        hit_sock  = wide ? {acc_addr[14], acc_addr[0]} : acc_addr[14:13];
        hit_off   = wide ? 15'(acc_addr[13:1]) : 15'(acc_addr[12:0]);
      end
      2'd2: begin
        in_region = &acc_addr[19:16];
        hit_sock  = wide ? {acc_addr[15], acc_addr[0]} : acc_addr[15:14];
        hit_off   = wide ? 15'(acc_addr[14:1]) : 15'(acc_addr[13:0]);
      end
      2'd3: begin
        in_region = &acc_addr[19:17];
        hit_sock  = wide ? {acc_addr[16], acc_addr[0]} : acc_addr[16:15];
        hit_off   = wide ? acc_addr[15:1] : acc_addr[14:0];
      end
      default: ;
    endcase
  end

  assign hit   = in_region && (sz[hit_sock] != 2'd0);
  assign wr_ok = hit && is_ram[hit_sock] && !(wide && hit_sock[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sz      <= '0;
      is_ram  <= '0;
      wide    <= 1'b0;
      cfg_err <= 1'b0;
      rd_data <= 8'hFF;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < DEPTH; j++)
          mem[i][j] <= 8'(j) ^ {2'(i), 6'b0};
    end else begin
      cfg_err <= 1'b0;
      if (cfg_valid) begin
        if (cfg_kind > 3'd5) begin
          cfg_err <= 1'b1;
        end else if (cfg_sock == 2'd3) begin
          if (req_ram) begin
            cfg_err <= 1'b1;
          end else begin
            sz     <= {req_sz, 6'b0};
            is_ram <= '0;
          end
        end else if (cfg_kind == 3'd0) begin
          sz[cfg_sock]     <= 2'd0;
          is_ram[cfg_sock] <= 1'b0;
        end else if (req_sz != top_sz || (req_ram && wide && cfg_sock == 2'd2)) begin
          cfg_err          <= 1'b1;
          sz[cfg_sock]     <= 2'd0;
          is_ram[cfg_sock] <= 1'b0;
        end else begin
          sz[cfg_sock]     <= req_sz;
          is_ram[cfg_sock] <= req_ram;
        end
      end
      if (mode_set) wide <= mode_wide;
      if (acc_valid) begin
        if (acc_write) begin
          if (wr_ok) mem[hit_sock][hit_off[STORE_AW-1:0]] <= acc_wdata;
        end else begin
          rd_data <= hit ? mem[hit_sock][hit_off[STORE_AW-1:0]] : 8'hFF;
        end
      end
    end
  end

  assert_top_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_sock == 2'd3 && (cfg_kind == 3'd4 || cfg_kind == 3'd5)
    |=> cfg_err && $stable(top_sz));

  assert_lower_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_sock == 2'd3 && cfg_kind <= 3'd3
    |=> sz[0] == 2'd0 && sz[1] == 2'd0 && sz[2] == 2'd0);

  assert_size_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_sock != 2'd3 && cfg_kind != 3'd0 && cfg_kind <= 3'd5 && req_sz != top_sz
    |=> cfg_err);

  assert_rom_unwritable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> hit && is_ram[hit_sock]);

  assert_miss_reads_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && !hit |=> rd_data == 8'hFF);

  assert_err_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> !cfg_err);

  assert_top_pair_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wide && hit_sock[1] |-> !wr_ok);
endmodule

// File: tb/socket_decoder_bench.sv
`timescale 1ns/1ps
module socket_decoder_bench;
  localparam int SAW = 8;
  localparam int SDEPTH = 1 << SAW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, mode_set = 0, mode_wide = 0, acc_valid = 0, acc_write = 0;
  logic [1:0] cfg_sock = 0;
  logic [2:0] cfg_kind = 0;
  logic [19:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic cfg_err, hit, wr_ok;
  logic [1:0] hit_sock;
  logic [14:0] hit_off;
  logic [7:0] rd_data;

  socket_decoder #(.STORE_AW(SAW)) u_socket_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sock(cfg_sock),
    .cfg_kind(cfg_kind), .mode_set(mode_set), .mode_wide(mode_wide),
    .cfg_err(cfg_err), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .hit(hit), .hit_sock(hit_sock),
    .hit_off(hit_off), .wr_ok(wr_ok), .rd_data(rd_data));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  int m_size [4];
  bit m_ram [4];
  bit m_wide;
  int m_store [4][SDEPTH];
  int exp_rd;
  bit exp_err;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  function automatic int kbytes(int code);
    case (code)
      1: return 8192;
      2: return 16384;
      3: return 32768;
      default: return 0;
    endcase
  endfunction

  task automatic model_decode(input int a, output bit h, output int s, output int off, output bit w);
    int sz, base, rel;
    h = 0; s = 0; off = 0; w = 0;
    sz = kbytes(m_size[3]);
    if (sz == 0) return;
    base = 'h100000 - 4 * sz;
    if (a < base) return;
    rel = a - base;
    if (!m_wide) begin
      s = rel / sz;
      off = rel % sz;
    end else begin
      s = (rel / (2 * sz)) * 2 + (a % 2);
      off = (rel % (2 * sz)) / 2;
    end
    h = (m_size[s] != 0);
    w = h && m_ram[s] && !(m_wide && s >= 2);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_size[i] = 0;
      m_ram[i] = 0;
      for (int j = 0; j < SDEPTH; j++) m_store[i][j] = (j % 256) ^ (i * 64);
    end
    m_wide = 0;
    exp_rd = 'hFF;
    exp_err = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit h, w;
      int s, off, k, rs, rr;
      model_decode(int'(acc_addr), h, s, off, w);
      if (acc_valid && acc_write && w) m_store[s][off % SDEPTH] = int'(acc_wdata);
      if (acc_valid && !acc_write) exp_rd = h ? m_store[s][off % SDEPTH] : 'hFF;
      exp_err = 0;
      if (cfg_valid) begin
        k = int'(cfg_kind);
        rr = (k >= 4) ? 1 : 0;
        rs = (k == 4) ? 1 : (k == 5) ? 3 : k;
        if (k > 5) exp_err = 1;
        else if (cfg_sock == 2'd3) begin
          if (rr == 1) exp_err = 1;
          else begin
            m_size[3] = rs;
            for (int i = 0; i < 3; i++) begin m_size[i] = 0; m_ram[i] = 0; end
          end
        end else if (k == 0) begin
          m_size[cfg_sock] = 0; m_ram[cfg_sock] = 0;
        end else if (rs != m_size[3] || (rr == 1 && m_wide && cfg_sock == 2'd2)) begin
          exp_err = 1;
          m_size[cfg_sock] = 0; m_ram[cfg_sock] = 0;
        end else begin
          m_size[cfg_sock] = rs; m_ram[cfg_sock] = (rr == 1);
        end
      end
      if (mode_set) m_wide = mode_wide;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit h, w;
      int s, off;
      model_decode(int'(acc_addr), h, s, off, w);
      chk("hit", int'(hit), int'(h));
      if (h) begin
        chk("hit_sock", int'(hit_sock), s);
        chk("hit_off", int'(hit_off), off);
      end
      chk("wr_ok", int'(wr_ok), int'(w));
      chk("rd_data", int'(rd_data), exp_rd);
      chk("cfg_err", int'(cfg_err), int'(exp_err));
    end
  end

  task automatic idle_inputs();
    cfg_valid = 0; mode_set = 0; acc_valid = 0; acc_write = 0;
  endtask

  task automatic cfg(input int s, input int k);
    @(negedge clk); #2; idle_inputs();
    cfg_valid = 1; cfg_sock = 2'(s); cfg_kind = 3'(k);
  endtask

  task automatic set_mode(input bit w);
    @(negedge clk); #2; idle_inputs();
    mode_set = 1; mode_wide = w;
  endtask

  task automatic rd(input int a);
    @(negedge clk); #2; idle_inputs();
    acc_valid = 1; acc_addr = 20'(a);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #2; idle_inputs();
    acc_valid = 1; acc_write = 1; acc_addr = 20'(a); acc_wdata = 8'(d);
  endtask

  task automatic idle();
    @(negedge clk); #2; idle_inputs();
  endtask

  initial begin
    acc_addr = 20'hFFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    phase = "R1";
    chk("reset rd_data", int'(rd_data), 'hFF);
    chk("reset cfg_err", int'(cfg_err), 0);
    chk("reset hit", int'(hit), 0);
    #2; rst_n = 1;
    rd('hFFFFF); rd('hF8000); idle();

    phase = "R2";
    cfg(3, 1); rd('hFE005); rd('hFFFFF); rd('hFDFFF);
    cfg(0, 1); rd('hF8010); cfg(1, 4); cfg(2, 1); rd('hFC123); idle();

    phase = "R8";
    wr('hFA010, 'hA5); rd('hFA010); wr('hF8010, 'h33); rd('hF8010);
    wr('h12345, 'h77); rd('hFA011); idle();

    phase = "R11";
    rd('hFE1FF); rd('hFE100); rd('hF9FFF); idle();

    phase = "R6";
    cfg(0, 2); rd('hF8010); cfg(1, 5); rd('hFA010); idle();

    phase = "R5";
    cfg(1, 4); cfg(3, 3); rd('hE0000); rd('hFFFFF); rd('hE8000); idle();

    phase = "R7";
    cfg(1, 5); wr('hE8004, 'h5C); rd('hE8004); cfg(0, 4); cfg(3, 2);
    cfg(1, 4); cfg(1, 5); cfg(2, 2); rd('hF8000); idle();

    phase = "R3";
    cfg(3, 1); set_mode(1); cfg(2, 1); cfg(1, 4); cfg(0, 1); cfg(2, 4); cfg(2, 1);
    rd('hFC000); rd('hFC001); rd('hF8001); rd('hFBFFE);
    wr('hF8003, 'h9E); rd('hF8003); wr('hF8002, 'h11); rd('hF8002);
    set_mode(0); cfg(2, 4); set_mode(1); wr('hFC004, 'h66); rd('hFC004); idle();

    phase = "R4";
    cfg(3, 4); rd('hFFFFF); cfg(3, 5); rd('hFFFFE); idle();

    phase = "R10";
    cfg(1, 6); rd('hF8003); cfg(3, 7); rd('hFFFFF); idle(); idle();

    phase = "R9";
    rd(0); rd('h12345); idle(); idle(); rd('hF8000);

    phase = "R12";
    @(negedge clk); #2; idle_inputs();
    cfg_valid = 1; cfg_sock = 2'd3; cfg_kind = 3'd3; acc_valid = 1; acc_addr = 20'hFE001;
    @(negedge clk); #2; idle_inputs();
    mode_set = 1; mode_wide = 0; acc_valid = 1; acc_addr = 20'hE0001;
    idle();

    phase = "R2 R3 R7 R8 random";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (r == 0) cfg(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)));
      else if (r <= 2) cfg(int'($urandom_range(0, 2)), int'($urandom_range(1, 5)));
      else if (r == 3) set_mode(1'($urandom_range(0, 1)));
      else if (r <= 10) wr(int'('hE0000 | $urandom_range(0, 'h1FFFF)), int'($urandom_range(0, 255)));
      else if (r <= 18) rd(int'('hE0000 | $urandom_range(0, 'h1FFFF)));
      else rd(int'($urandom_range(0, 'hFFFFF)));
    end
    idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule